// File: doc/BRIEF.md
# Burst Master Requester

This block is user logic that issues master transactions through a bus adapter. A command gives a start address, a direction, a 4-bit burst count, a bus-lock choice and a base index into a small local data buffer. While the transaction runs, the block drives a request together with the address, byte enables, burst and lock qualifiers and the current local buffer index. It then steps through the per-beat acknowledges until the transaction ends.

For writes, each beat's data is read from the local buffer. For reads, each acknowledged beat is stored into the buffer. A transaction can end in three ways: a last-acknowledge that comes with the final beat, a timeout, or a retry. After a retry the whole transaction is restarted, up to a set number of times. An error input that comes with any acknowledge is kept in a sticky flag until the next command. The user side loads and inspects the buffer through its own write and read port.

Top module: `mrq_burst_master`

## Requirements
- R1: After reset, mst_req_o, mst_lock_o, busy_o, done_o, fail_o and err_o are all 0.
- R2: A cmd_start_i seen while idle raises mst_req_o in the next cycle. In that cycle mst_addr_o is the command address, mst_rnw_o is the direction (1 = read), mst_num_o is the count, mst_burst_o is 1 exactly when the count is nonzero, and mst_be_o is all ones. The burst length is count+1, so count 0 is one beat and count 15 is sixteen beats.
- R3: While mst_req_o stays high, mst_addr_o holds the command address.
- R4: mst_local_o equals the base index plus the number of beats acknowledged so far, modulo BUF_DEPTH. On a write, wr_data_o is the buffer word at that index.
- R5: On a read, each cycle with mst_ack_i high stores rd_data_i into the buffer at mst_local_o. The word can later be read through buf_raddr_i and buf_rdata_o.
- R6: When mst_last_ack_i (which comes together with the final mst_ack_i) is sampled, mst_req_o and busy_o fall in the next cycle and done_o pulses for exactly one cycle.
- R7: When mst_timeout_i is sampled during a request, the transaction ends. fail_o pulses for one cycle and done_o stays 0.
- R8: When mst_retry_i is sampled, mst_req_o drops for one cycle. The transaction then restarts from the same address with mst_local_o back at the base index, for at most MAX_RETRY restarts. A retry after the last allowed restart ends the transaction with a fail_o pulse.
- R9: err_o is set when mst_error_i is high in a cycle where mst_ack_i is high. mst_error_i without mst_ack_i has no effect. err_o is cleared in the cycle after the next accepted command.
- R10: mst_lock_o equals the command's lock bit while mst_req_o is high, and is 0 otherwise.
- R11: cmd_start_i while busy has no effect on the address, count, direction or local index of the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Start a command (taken only when idle) |
| cmd_addr_i | input | ADDR_W | Start address on the host bus |
| cmd_rnw_i | input | 1 | 1 = read, 0 = write |
| cmd_count_i | input | 4 | Burst count; length is count+1 |
| cmd_lock_i | input | 1 | Hold the bus for the transaction |
| cmd_local_i | input | log2(BUF_DEPTH) | Base index in the local buffer |
| mst_req_o | output | 1 | Transaction request |
| mst_rnw_o | output | 1 | Direction qualifier |
| mst_addr_o | output | ADDR_W | Transaction address |
| mst_be_o | output | DATA_W/8 | Byte enables |
| mst_burst_o | output | 1 | Burst qualifier |
| mst_lock_o | output | 1 | Bus-lock qualifier |
| mst_num_o | output | 4 | Burst count field |
| mst_local_o | output | log2(BUF_DEPTH) | Local source/sink index of the current beat |
| wr_data_o | output | DATA_W | Write data for the current beat |
| mst_ack_i | input | 1 | Per-beat acknowledge |
| mst_last_ack_i | input | 1 | Final acknowledge |
| mst_retry_i | input | 1 | Retry completion |
| mst_timeout_i | input | 1 | Timeout completion |
| mst_error_i | input | 1 | Error qualifier for an acknowledge |
| rd_data_i | input | DATA_W | Read data for the current beat |
| buf_we_i | input | 1 | User buffer write enable |
| buf_waddr_i | input | log2(BUF_DEPTH) | User buffer write index |
| buf_wdata_i | input | DATA_W | User buffer write data |
| buf_raddr_i | input | log2(BUF_DEPTH) | User buffer read index |
| buf_rdata_o | output | DATA_W | User buffer read data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| err_o | output | 1 | Sticky error flag |

## Verification
The bench builds the block with BUF_DEPTH 8, MAX_RETRY 2 and 32-bit data. It sweeps all sixteen burst counts in both directions, with the base index stepping through the buffer. Because the buffer is only 8 entries deep, every burst longer than eight beats wraps the local index. A depth-2 retry limit makes both the restart path and the exhausted-retry failure reachable in a few cycles. Wait cycles that carry a stray error input without an acknowledge are mixed into the sweep, so the error flag is checked against acknowledged beats only.

// File: rtl/mrq_pkg.sv
package mrq_pkg;
  localparam int unsigned NUM_W = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_GAP} mrq_state_e;
endpackage

// File: rtl/mrq_buf.sv
module mrq_buf #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LOC_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              mst_we_i,
  input  logic [LOC_W-1:0]  mst_idx_i,
  input  logic [DATA_W-1:0] mst_wdata_i,
  output logic [DATA_W-1:0] mst_rdata_o,
  input  logic              usr_we_i,
  input  logic [LOC_W-1:0]  usr_widx_i,
  input  logic [DATA_W-1:0] usr_wdata_i,
  input  logic [LOC_W-1:0]  usr_ridx_i,
  output logic [DATA_W-1:0] usr_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // master side wins on a same-cycle write
  always_ff @(posedge clk_i) begin
    if (mst_we_i) mem_q[mst_idx_i] <= mst_wdata_i;
    else if (usr_we_i) mem_q[usr_widx_i] <= usr_wdata_i;
  end

  assign mst_rdata_o = mem_q[mst_idx_i];
  assign usr_rdata_o = mem_q[usr_ridx_i];
endmodule

// File: rtl/mrq_ctrl.sv
module mrq_ctrl
  import mrq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned MAX_RETRY = 2,
  localparam int unsigned LOC_W    = $clog2(DEPTH),
  localparam int unsigned BE_W     = DATA_W / 8,
  localparam int unsigned RETRY_W  = $clog2(MAX_RETRY + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_rnw_i,
  input  logic [NUM_W-1:0]  cmd_count_i,
  input  logic              cmd_lock_i,
  input  logic [LOC_W-1:0]  cmd_local_i,
  output logic              req_o,
  output logic              rnw_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_o,
  output logic              burst_o,
  output logic              lock_o,
  output logic [NUM_W-1:0]  num_o,
  output logic [LOC_W-1:0]  local_o,
  output logic              buf_we_o,
  input  logic              ack_i,
  input  logic              last_ack_i,
  input  logic              retry_i,
  input  logic              timeout_i,
  input  logic              error_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              err_o
);
  mrq_state_e         st_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               rnw_q, lock_q;
  logic [NUM_W-1:0]   cnt_q, beat_q;
  logic [LOC_W-1:0]   base_q;
  logic [RETRY_W-1:0] retry_q;
  logic               err_q, done_q, fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      rnw_q   <= 1'b0;
      lock_q  <= 1'b0;
      cnt_q   <= '0;
      beat_q  <= '0;
      base_q  <= '0;
      retry_q <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cmd_start_i) begin
          addr_q  <= cmd_addr_i;
          rnw_q   <= cmd_rnw_i;
          lock_q  <= cmd_lock_i;
          cnt_q   <= cmd_count_i;
          base_q  <= cmd_local_i;
          beat_q  <= '0;
          retry_q <= '0;
          err_q   <= 1'b0;
          st_q    <= ST_REQ;
        end
        ST_REQ: begin
          if (ack_i && error_i) err_q <= 1'b1;
          if (ack_i) beat_q <= beat_q + 1'b1;
          if (last_ack_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else if (timeout_i) begin
            st_q   <= ST_IDLE;
            fail_q <= 1'b1;
          end else if (retry_i) begin
            if (retry_q == RETRY_W'(MAX_RETRY)) begin
              st_q   <= ST_IDLE;
              fail_q <= 1'b1;
            end else begin
              retry_q <= retry_q + 1'b1;
              beat_q  <= '0;
              st_q    <= ST_GAP;
            end
          end
        end
        ST_GAP:  st_q <= ST_REQ;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o    = (st_q == ST_REQ);
  assign rnw_o    = rnw_q;
  assign addr_o   = addr_q;
  assign be_o     = req_o ? {BE_W{1'b1}} : '0;
  assign burst_o  = (cnt_q != '0);
  assign lock_o   = lock_q && req_o;
  assign num_o    = cnt_q;
  assign local_o  = base_q + LOC_W'(beat_q);
  assign buf_we_o = req_o && ack_i && rnw_q;
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign fail_o   = fail_q;
  assign err_o    = err_q;

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_start_i) |=> (req_o && addr_o == $past(cmd_addr_i)));
  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(req_o)) |-> $stable(addr_o));
  assert_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && last_ack_i) |=> (!req_o && done_o && !fail_o));
  assert_timeout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && timeout_i && !last_ack_i) |=> (fail_o && !done_o && !busy_o));
  assert_retry_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && retry_i && !last_ack_i && !timeout_i && retry_q != RETRY_W'(MAX_RETRY))
    |=> (!req_o && busy_o && local_o == base_q));
  assert_err_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(st_q == ST_IDLE && cmd_start_i)) |=> err_o);
  assert_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> req_o);
  assert_busy_cmd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(num_o) && $stable(rnw_o)));
endmodule

// File: rtl/mrq_burst_master.sv
module mrq_burst_master #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUF_DEPTH = 16,
  parameter int unsigned MAX_RETRY = 2,
  localparam int unsigned LOC_W    = $clog2(BUF_DEPTH),
  localparam int unsigned BE_W     = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              cmd_rnw_i,
  input  logic [3:0]        cmd_count_i,
  input  logic              cmd_lock_i,
  input  logic [LOC_W-1:0]  cmd_local_i,
  output logic              mst_req_o,
  output logic              mst_rnw_o,
  output logic [ADDR_W-1:0] mst_addr_o,
  output logic [BE_W-1:0]   mst_be_o,
  output logic              mst_burst_o,
  output logic              mst_lock_o,
  output logic [3:0]        mst_num_o,
  output logic [LOC_W-1:0]  mst_local_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              mst_ack_i,
  input  logic              mst_last_ack_i,
  input  logic              mst_retry_i,
  input  logic              mst_timeout_i,
  input  logic              mst_error_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              buf_we_i,
  input  logic [LOC_W-1:0]  buf_waddr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic [LOC_W-1:0]  buf_raddr_i,
  output logic [DATA_W-1:0] buf_rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              err_o
);
  logic rd_we;

  mrq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(BUF_DEPTH), .MAX_RETRY(MAX_RETRY)
  ) ctrl_i (
    .clk_i, .rst_ni, .cmd_start_i, .cmd_addr_i, .cmd_rnw_i, .cmd_count_i,
    .cmd_lock_i, .cmd_local_i,
    .req_o(mst_req_o), .rnw_o(mst_rnw_o), .addr_o(mst_addr_o), .be_o(mst_be_o),
    .burst_o(mst_burst_o), .lock_o(mst_lock_o), .num_o(mst_num_o),
    .local_o(mst_local_o), .buf_we_o(rd_we),
    .ack_i(mst_ack_i), .last_ack_i(mst_last_ack_i), .retry_i(mst_retry_i),
    .timeout_i(mst_timeout_i), .error_i(mst_error_i),
    .busy_o, .done_o, .fail_o, .err_o
  );

  mrq_buf #(.DEPTH(BUF_DEPTH), .DATA_W(DATA_W)) buf_i (
    .clk_i,
    .mst_we_i(rd_we), .mst_idx_i(mst_local_o), .mst_wdata_i(rd_data_i),
    .mst_rdata_o(wr_data_o),
    .usr_we_i(buf_we_i), .usr_widx_i(buf_waddr_i), .usr_wdata_i(buf_wdata_i),
    .usr_ridx_i(buf_raddr_i), .usr_rdata_o(buf_rdata_o)
  );
endmodule

// File: tb/mrq_burst_master_tb_top.sv
module mrq_burst_master_tb_top;
  localparam int D = 8;
  localparam int LW = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_start_i = 0, cmd_rnw_i = 0, cmd_lock_i = 0;
  logic [31:0] cmd_addr_i = '0;
  logic [3:0] cmd_count_i = '0;
  logic [LW-1:0] cmd_local_i = '0;
  logic mst_req_o, mst_rnw_o, mst_burst_o, mst_lock_o;
  logic [31:0] mst_addr_o, wr_data_o, buf_rdata_o;
  logic [3:0] mst_be_o, mst_num_o;
  logic [LW-1:0] mst_local_o;
  logic mst_ack_i = 0, mst_last_ack_i = 0, mst_retry_i = 0, mst_timeout_i = 0, mst_error_i = 0;
  logic [31:0] rd_data_i = '0, buf_wdata_i = '0;
  logic buf_we_i = 0;
  logic [LW-1:0] buf_waddr_i = '0, buf_raddr_i = '0;
  logic busy_o, done_o, fail_o, err_o;

  int checks = 0, errors = 0;
  logic [31:0] model [D];

  always #4 clk_i = ~clk_i;

  mrq_burst_master #(.BUF_DEPTH(D), .MAX_RETRY(2)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic start_cmd(input bit rnw, input int cnt, input int base, input bit lk, input logic [31:0] a);
    cmd_start_i = 1; cmd_rnw_i = rnw; cmd_count_i = 4'(cnt);
    cmd_local_i = LW'(base); cmd_lock_i = lk; cmd_addr_i = a;
    step();
    cmd_start_i = 0;
    chk(mst_req_o == 1, "R2 req", 32'(mst_req_o), 1);
    chk(mst_addr_o == a, "R2 addr", mst_addr_o, a);
    chk(mst_num_o == 4'(cnt), "R2 num", 32'(mst_num_o), 32'(cnt));
    chk(mst_rnw_o == rnw, "R2 rnw", 32'(mst_rnw_o), 32'(rnw));
    chk(mst_burst_o == (cnt != 0), "R2 burst", 32'(mst_burst_o), 32'(cnt != 0));
    chk(mst_be_o == 4'hF, "R2 be", 32'(mst_be_o), 32'hF);
    chk(mst_lock_o == lk, "R10 lock", 32'(mst_lock_o), 32'(lk));
    chk(err_o == 0, "R9 cleared", 32'(err_o), 0);
  endtask

  // runs n beats; wait cycles carry error without ack
  task automatic beats(input bit rnw, input int n, input int base, input logic [31:0] a,
                       input bit last, input int err_at);
    for (int b = 0; b < n; b++) begin
      if (b % 3 == 1) begin
        mst_error_i = 1;
        step();
        mst_error_i = 0;
        chk(mst_req_o == 1, "R2 held", 32'(mst_req_o), 1);
      end
      chk(mst_local_o == LW'(base + b), "R4 local", 32'(mst_local_o), 32'((base + b) % D));
      chk(mst_addr_o == a, "R3 addr", mst_addr_o, a);
      if (!rnw) chk(wr_data_o == model[(base + b) % D], "R4 wdata", wr_data_o, model[(base + b) % D]);
      else begin
        rd_data_i = 32'hC0DE_0000 + 32'(a[7:0]) * 256 + 32'(b);
        model[(base + b) % D] = rd_data_i;
      end
      mst_ack_i = 1; mst_last_ack_i = last && (b == n - 1); mst_error_i = (b == err_at);
      step();
      mst_ack_i = 0; mst_last_ack_i = 0; mst_error_i = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step();
    chk(!mst_req_o && !mst_lock_o && !busy_o && !done_o && !fail_o && !err_o, "R1 reset",
        {26'd0, mst_req_o, mst_lock_o, busy_o, done_o, fail_o, err_o}, 0);
    rst_ni = 1;
    step();
    for (int i = 0; i < D; i++) begin
      buf_we_i = 1; buf_waddr_i = LW'(i); buf_wdata_i = 32'h5A00_0000 + 32'(i * 17);
      model[i] = buf_wdata_i;
      step();
    end
    buf_we_i = 0;

    // sweep all counts, both directions
    for (int c = 0; c < 16; c++) begin
      for (int r = 0; r < 2; r++) begin
        logic [31:0] a;
        int eat;
        a = 32'h1000_0000 + 32'(c * 64 + r * 4);
        eat = (c == 5) ? 2 : 99;
        start_cmd(r[0], c, c % D, c[0], a);
        beats(r[0], c + 1, c % D, a, 1'b1, eat);
        chk(!mst_req_o && !busy_o && done_o && !fail_o, "R6 done",
            {29'd0, mst_req_o, busy_o, done_o}, 1);
        chk(mst_lock_o == 0, "R10 lock idle", 32'(mst_lock_o), 0);
        chk(err_o == (c == 5), "R9 err", 32'(err_o), 32'(c == 5));
        step();
        chk(done_o == 0, "R6 pulse", 32'(done_o), 0);
        for (int i = 0; i < D; i++) begin
          buf_raddr_i = LW'(i);
          #1;
          chk(buf_rdata_o == model[i], "R5 buffer", buf_rdata_o, model[i]);
        end
      end
    end

    // retries then exhausted
    start_cmd(1'b0, 3, 2, 1'b0, 32'hAAAA_0000);
    beats(1'b0, 1, 2, 32'hAAAA_0000, 1'b0, 99);
    for (int k = 0; k < 2; k++) begin
      mst_retry_i = 1; step(); mst_retry_i = 0;
      chk(!mst_req_o && busy_o, "R8 gap", {30'd0, mst_req_o, busy_o}, 1);
      step();
      chk(mst_req_o && mst_local_o == 2 && mst_addr_o == 32'hAAAA_0000, "R8 restart",
          32'(mst_local_o), 2);
    end
    mst_retry_i = 1; step(); mst_retry_i = 0;
    chk(fail_o && !done_o && !busy_o && !mst_req_o, "R8 exhausted",
        {28'd0, fail_o, done_o, busy_o, mst_req_o}, 32'h8);

    // timeout
    step();
    start_cmd(1'b1, 7, 4, 1'b1, 32'hBBBB_0040);
    beats(1'b1, 2, 4, 32'hBBBB_0040, 1'b0, 99);
    mst_timeout_i = 1; step(); mst_timeout_i = 0;
    chk(fail_o && !done_o && !busy_o, "R7 timeout", {29'd0, fail_o, done_o, busy_o}, 32'h4);
    step();
    chk(fail_o == 0, "R7 pulse", 32'(fail_o), 0);

    // start while busy ignored
    start_cmd(1'b0, 2, 1, 1'b0, 32'hCCCC_0000);
    cmd_start_i = 1; cmd_addr_i = 32'hDEAD_0000; cmd_count_i = 4'd9; cmd_local_i = 3'd6; cmd_rnw_i = 1;
    step();
    cmd_start_i = 0;
    chk(mst_addr_o == 32'hCCCC_0000 && mst_num_o == 2 && !mst_rnw_o, "R11 ignore",
        mst_addr_o, 32'hCCCC_0000);
    beats(1'b0, 3, 1, 32'hCCCC_0000, 1'b1, 99);
    chk(done_o == 1, "R11 done", 32'(done_o), 1);
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule